// File: doc/BRIEF.md
# I2C Target with Bus Timeout

This block is the serial-bus target front end of a sensor-style register bank. It follows the two-wire bus (clock and open-drain data) through two-flop synchronizers and recognises start and stop conditions. It matches a 7-bit target address followed by a direction bit and acknowledges bytes addressed to it. The first data byte of a write sets an 8-bit register pointer. Later bytes arrive in pairs, high byte first, and update 16-bit registers. A read returns the register that the pointer selects, high byte first.

The data line is driven only through an output enable that pulls the line low. Every change of that enable happens while the clock is low. A stall watchdog counts consecutive system-clock cycles with the bus clock held low. When the programmed limit is reached, the protocol engine returns to idle and releases the data line, so a controller that stops mid-transfer cannot hold the bus. The limit defaults to 28 ms worth of system clocks.

Top module: `i2c_lux_target`

## Requirements
- R1: A fall of the data line while the clock is high starts address reception, and bits are shifted in on clock rising edges, most significant bit first.
- R2: When the upper seven bits of the address byte equal DEV_ADDR, the target pulls the data line low for the ninth clock; for any other address the data line stays released and later bytes are ignored until the next start.
- R3: In a write (direction bit 0), the first data byte loads the pointer, and each later pair of bytes (high byte, then low byte) writes the selected register. Every byte is acknowledged.
- R4: In a read (direction bit 1), the target sends the selected register, high byte then low byte, and repeats that order while the controller keeps acknowledging. Pointer 01h holds configuration (reset C810h), 02h holds the low limit (reset C000h), 03h holds the high limit (reset BFFFh), 7Eh reads 5449h, 7Fh reads 3001h, and 00h reads the `result_i` input.
- R5: Writes to pointers 00h, 7Eh, 7Fh and to unmapped pointers change no register, and unmapped pointers read 0000h.
- R6: After the controller answers a read byte with no acknowledge, the target releases the data line and drives nothing until the next start.
- R7: A rise of the data line while the clock is high returns the engine to idle and releases the data line.
- R8: A start seen in the middle of a transaction, including in the middle of a byte, restarts address reception.
- R9: The data-line enable only turns on while the synchronized clock is low.
- R10: If the clock stays low for STALL_CYC consecutive system clocks, the engine returns to idle and releases the data line; shorter low periods have no effect.
- R11: After reset the data line is released and the registers hold their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| result_i | input | 16 | Measurement value read at pointer 00h |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The address match is tried with all 128 seven-bit addresses, which separates the single matching address from every near miss in any bit. Register writes use all-zero, all-ones and arithmetically derived mixed patterns on each writable register, and each is read back. This exposes byte swaps, stuck bits and writes that reach the wrong register. Read-only, unmapped and sensor-fed pointers show which writes must have no effect. The bus sequences cover repeated starts between bytes and inside a byte, controller no-acknowledge, multi-byte reads, and clock-low stalls just short of and just past the limit. Together these separate a correct restart, release or timeout from a stale engine state.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eng_st_e;

    typedef enum logic [1:0] {
        WP_PTR,
        WP_HI,
        WP_LO
    } wr_phase_e;

    localparam logic [7:0] PTR_RESULT = 8'h00;
    localparam logic [7:0] PTR_CFG    = 8'h01;
    localparam logic [7:0] PTR_LOLIM  = 8'h02;
    localparam logic [7:0] PTR_HILIM  = 8'h03;
    localparam logic [7:0] PTR_MFR    = 8'h7E;
    localparam logic [7:0] PTR_DEVID  = 8'h7F;

    localparam logic [15:0] RST_CFG   = 16'hC810;
    localparam logic [15:0] RST_LOLIM = 16'hC000;
    localparam logic [15:0] RST_HILIM = 16'hBFFF;
    localparam logic [15:0] VAL_MFR   = 16'h5449;
    localparam logic [15:0] VAL_DEVID = 16'h3001;

    typedef struct packed {
        logic [15:0] cfg;
        logic [15:0] lolim;
        logic [15:0] hilim;
    } regs_s;

    typedef struct packed {
        eng_st_e    st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic       is_addr;
        logic       rd;
        wr_phase_e  wph;
        logic [7:0] ptr;
        logic [7:0] hold;
        logic       hi_next;
        logic       mack;
        logic       oe;
    } eng_s;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int DEPTH = STAGES + 1;

    logic [1:0] pin_raw;
    logic [1:0] cur;
    logic [1:0] prev;

    assign pin_raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_pin
        logic [DEPTH-1:0] pipe_d, pipe_q;

        always_comb pipe_d = {pipe_q[DEPTH-2:0], pin_raw[g]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign cur[g]  = pipe_q[STAGES-1];
        assign prev[g] = pipe_q[STAGES];
    end

    assign scl_s    = cur[1];
    assign sda_s    = cur[0];
    assign scl_rise = cur[1] & ~prev[1];
    assign scl_fall = ~cur[1] & prev[1];
    assign start_ev = cur[1] & prev[1] & prev[0] & ~cur[0];
    assign stop_ev  = cur[1] & prev[1] & ~prev[0] & cur[0];

endmodule

// File: rtl/i2c_stall_wdog.sv
module i2c_stall_wdog #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    output logic tmo
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_TOP = W'(LIMIT);
    localparam logic [W-1:0] LIM_M1  = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (scl_s)                 cnt_d = '0;
        else if (cnt_q == LIM_TOP) cnt_d = cnt_q;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tmo = ~scl_s & (cnt_q == LIM_M1);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> (cnt_q == LIM_TOP));

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_tgt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  ptr,
    input  logic [15:0] wr_data,
    input  logic [15:0] result_i,
    output logic [15:0] rd_data
);
    regs_s regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (ptr)
                PTR_CFG:   regs_d.cfg   = wr_data;
                PTR_LOLIM: regs_d.lolim = wr_data;
                PTR_HILIM: regs_d.hilim = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.cfg   <= RST_CFG;
            regs_q.lolim <= RST_LOLIM;
            regs_q.hilim <= RST_HILIM;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (ptr)
            PTR_RESULT: rd_data = result_i;
            PTR_CFG:    rd_data = regs_q.cfg;
            PTR_LOLIM:  rd_data = regs_q.lolim;
            PTR_HILIM:  rd_data = regs_q.hilim;
            PTR_MFR:    rd_data = VAL_MFR;
            PTR_DEVID:  rd_data = VAL_DEVID;
            default:    rd_data = 16'h0000;
        endcase
    end

    // R5
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr != PTR_CFG && ptr != PTR_LOLIM && ptr != PTR_HILIM)
        |=> $stable(regs_q));

endmodule

// File: rtl/i2c_lux_target.sv
module i2c_lux_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h44,
    parameter int         CLK_HZ      = 125_000_000,
    parameter int         STALL_US    = 28_000,
    parameter int         STALL_CYC   = (CLK_HZ / 1_000_000) * STALL_US,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [15:0] result_i,
    output logic        sda_oe_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic tmo;
    logic wr_en;
    logic [15:0] wr_data, rd_data;
    logic [7:0]  tx_byte;
    eng_s eng_d, eng_q;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2c_stall_wdog #(.LIMIT(STALL_CYC)) wdog_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .tmo(tmo)
    );

    i2c_reg_bank bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(eng_q.ptr),
        .wr_data(wr_data), .result_i(result_i), .rd_data(rd_data)
    );

    assign wr_data = {eng_q.hold, eng_q.sh};
    assign tx_byte = eng_q.hi_next ? rd_data[15:8] : rd_data[7:0];

    always_comb begin
        eng_d = eng_q;
        wr_en = 1'b0;
        if (tmo) begin
            eng_d.st = ST_IDLE;
            eng_d.oe = 1'b0;
        end else if (start_ev) begin
            eng_d.st      = ST_RX;
            eng_d.is_addr = 1'b1;
            eng_d.cnt     = '0;
            eng_d.oe      = 1'b0;
        end else if (stop_ev) begin
            eng_d.st = ST_IDLE;
            eng_d.oe = 1'b0;
        end else begin
            case (eng_q.st)
                ST_RX: begin
                    if (scl_rise && eng_q.cnt < 4'd8) begin
                        eng_d.sh  = {eng_q.sh[6:0], sda_s};
                        eng_d.cnt = eng_q.cnt + 4'd1;
                    end else if (scl_fall && eng_q.cnt == 4'd8) begin
                        if (eng_q.is_addr) begin
                            if (eng_q.sh[7:1] == DEV_ADDR) begin
                                eng_d.st      = ST_ACK;
                                eng_d.oe      = 1'b1;
                                eng_d.rd      = eng_q.sh[0];
                                eng_d.wph     = WP_PTR;
                                eng_d.hi_next = 1'b1;
                            end else begin
                                eng_d.st = ST_IDLE;
                            end
                        end else begin
                            eng_d.st = ST_ACK;
                            eng_d.oe = 1'b1;
                            case (eng_q.wph)
                                WP_PTR: begin
                                    eng_d.ptr = eng_q.sh;
                                    eng_d.wph = WP_HI;
                                end
                                WP_HI: begin
                                    eng_d.hold = eng_q.sh;
                                    eng_d.wph  = WP_LO;
                                end
                                default: begin
                                    wr_en     = 1'b1;
                                    eng_d.wph = WP_HI;
                                end
                            endcase
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        eng_d.cnt = '0;
                        if (eng_q.rd) begin
                            eng_d.st      = ST_TX;
                            eng_d.sh      = tx_byte;
                            eng_d.oe      = ~tx_byte[7];
                            eng_d.hi_next = ~eng_q.hi_next;
                        end else begin
                            eng_d.st      = ST_RX;
                            eng_d.is_addr = 1'b0;
                            eng_d.oe      = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise && eng_q.cnt < 4'd8) begin
                        eng_d.cnt = eng_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (eng_q.cnt == 4'd8) begin
                            eng_d.oe = 1'b0;
                            eng_d.st = ST_MACK;
                        end else begin
                            eng_d.sh = {eng_q.sh[6:0], 1'b0};
                            eng_d.oe = ~eng_q.sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        eng_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (eng_q.mack) begin
                            eng_d.st      = ST_TX;
                            eng_d.cnt     = '0;
                            eng_d.sh      = tx_byte;
                            eng_d.oe      = ~tx_byte[7];
                            eng_d.hi_next = ~eng_q.hi_next;
                        end else begin
                            eng_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, cnt: '0, sh: '0, is_addr: 1'b0, rd: 1'b0,
                       wph: WP_PTR, ptr: '0, hold: '0, hi_next: 1'b1,
                       mack: 1'b0, oe: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_oe_o = eng_q.oe;

    // R9
    oe_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !$past(scl_s));

    // R10
    stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> (eng_q.st == ST_IDLE) && !sda_oe_o);

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (eng_q.st == ST_IDLE) && !sda_oe_o);

    // R8
    restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (eng_q.st == ST_RX) && eng_q.is_addr && (eng_q.cnt == 4'd0));

endmodule

// File: tb/i2c_lux_target_tb.sv
module i2c_lux_target_tb_top;
    localparam int Q    = 8;
    localparam int STALL = 400;
    localparam logic [6:0] ADDR = 7'h44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m_low = 1'b0;
    logic [15:0] result_val = 16'h3A7C;
    logic sda_oe;
    logic sda_line;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m_cfg = 16'hC810;
    logic [15:0] m_lo  = 16'hC000;
    logic [15:0] m_hi  = 16'hBFFF;

    always #4 clk = ~clk;

    assign sda_line = !(sda_m_low || sda_oe);

    i2c_lux_target #(.DEV_ADDR(ADDR), .STALL_CYC(STALL)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .result_i(result_val), .sda_oe_o(sda_oe)
    );

    function automatic logic [15:0] exp_reg(input logic [7:0] p);
        case (p)
            8'h00:   return result_val;
            8'h01:   return m_cfg;
            8'h02:   return m_lo;
            8'h03:   return m_hi;
            8'h7E:   return 16'h5449;
            8'h7F:   return 16'h3001;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m_low = 1'b0; wait_q(1);
        scl = 1'b1;       wait_q(1);
        sda_m_low = 1'b1; wait_q(1);
        scl = 1'b0;       wait_q(1);
    endtask

    task automatic bus_stop();
        sda_m_low = 1'b1; wait_q(1);
        scl = 1'b1;       wait_q(1);
        sda_m_low = 1'b0; wait_q(2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m_low = !b[i]; wait_q(1);
            scl = 1'b1;        wait_q(2);
            scl = 1'b0;        wait_q(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m_low = 1'b0; wait_q(1);
        scl = 1'b1;       wait_q(1);
        ack = !sda_line;  wait_q(1);
        scl = 1'b0;       wait_q(1);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_q(1);
            scl = 1'b1;  wait_q(1);
            b[i] = sda_line; wait_q(1);
            scl = 1'b0;
        end
        wait_q(1);
        sda_m_low = give_ack; wait_q(1);
        scl = 1'b1;           wait_q(2);
        scl = 1'b0;           wait_q(1);
        sda_m_low = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] p, input logic [15:0] v);
        logic a0, a1, a2, a3;
        bus_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(p, a1);
        send_byte(v[15:8], a2);
        send_byte(v[7:0], a3);
        bus_stop();
        chk("R3 write bytes acknowledged", {12'h0, a0, a1, a2, a3}, 16'h000F);
    endtask

    task automatic rd_reg(input logic [7:0] p, output logic [15:0] v);
        logic a;
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(p, a);
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        recv_byte(1'b1, v[15:8]);
        recv_byte(1'b0, v[7:0]);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [15:0] v;
        logic [7:0] b;
        logic [15:0] pat;
        logic [7:0] ptr_list [12];

        repeat (5) @(negedge clk);
        chk("R11 data line released in reset", {15'h0, sda_oe}, 16'h0000);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 data line released after reset", {15'h0, sda_oe}, 16'h0000);

        // R11 / R4: reset values and fixed registers
        ptr_list = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h7E, 8'h7F,
                     8'h04, 8'h05, 8'h40, 8'h7D, 8'h80, 8'hFF};
        for (int k = 0; k < 12; k++) begin
            rd_reg(ptr_list[k], v);
            chk("R4 R11 read by pointer", v, exp_reg(ptr_list[k]));
        end

        // R1 R2: address sweep over all seven-bit addresses
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            chk("R2 address match ack", {15'h0, ack}, {15'h0, (7'(a) == ADDR)});
            bus_stop();
        end

        // R3: pattern sweep over writable registers
        for (int p = 1; p <= 3; p++) begin
            for (int k = 0; k < 4; k++) begin
                case (k)
                    0: pat = 16'h0000;
                    1: pat = 16'hFFFF;
                    default: pat = 16'(16'h1357 * (k + 1) + p * 16'h0101);
                endcase
                wr_reg(8'(p), pat);
                case (p)
                    1: m_cfg = pat;
                    2: m_lo  = pat;
                    default: m_hi = pat;
                endcase
                rd_reg(8'(p), v);
                chk("R3 write then read back", v, exp_reg(8'(p)));
            end
        end
        for (int p = 1; p <= 3; p++) begin
            rd_reg(8'(p), v);
            chk("R3 no cross writes", v, exp_reg(8'(p)));
        end

        // R3: two data pairs in one write, last one wins
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h03, ack);
        send_byte(8'h11, ack); send_byte(8'h11, ack);
        send_byte(8'h22, ack); send_byte(8'h33, ack);
        bus_stop();
        m_hi = 16'h2233;
        rd_reg(8'h03, v);
        chk("R3 second pair written", v, 16'h2233);

        // R5: writes to read-only and unmapped pointers
        wr_reg(8'h7E, 16'h0000); rd_reg(8'h7E, v); chk("R5 mfr id unchanged", v, 16'h5449);
        wr_reg(8'h7F, 16'hFFFF); rd_reg(8'h7F, v); chk("R5 dev id unchanged", v, 16'h3001);
        wr_reg(8'h00, 16'h1234); rd_reg(8'h00, v); chk("R5 result follows input", v, 16'h3A7C);
        wr_reg(8'h10, 16'h5555); rd_reg(8'h10, v); chk("R5 unmapped reads zero", v, 16'h0000);
        for (int p = 1; p <= 3; p++) begin
            rd_reg(8'(p), v);
            chk("R5 writable regs untouched", v, exp_reg(8'(p)));
        end
        result_val = 16'hC35A;
        rd_reg(8'h00, v); chk("R4 result input tracked", v, 16'hC35A);

        // R4: read with stored pointer, four bytes
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        recv_byte(1'b1, v[15:8]); recv_byte(1'b1, v[7:0]);
        chk("R4 read with kept pointer", v, 16'hC35A);
        recv_byte(1'b1, v[15:8]); recv_byte(1'b0, v[7:0]);
        chk("R4 repeat high then low", v, 16'hC35A);
        // R6: after NACK the target drives nothing
        recv_byte(1'b0, b);
        chk("R6 released after nack", {8'h0, b}, 16'h00FF);
        bus_stop();
        chk("R7 released after stop", {15'h0, sda_oe}, 16'h0000);

        // R8: restart inside a byte
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h7F, ack);
        send_bits(8'h0A, 4);
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        chk("R8 address acked after mid-byte restart", {15'h0, ack}, 16'h0001);
        recv_byte(1'b1, v[15:8]); recv_byte(1'b0, v[7:0]);
        bus_stop();
        chk("R8 read after mid-byte restart", v, 16'h3001);

        // R10: clock stall during acknowledge
        bus_start();
        send_bits({ADDR, 1'b0}, 8);
        sda_m_low = 1'b0;
        repeat (12) @(negedge clk);
        chk("R2 ack driven before stall", {15'h0, sda_oe}, 16'h0001);
        repeat (280) @(negedge clk);
        chk("R10 short low keeps state", {15'h0, sda_oe}, 16'h0001);
        repeat (150) @(negedge clk);
        chk("R10 stall releases line", {15'h0, sda_oe}, 16'h0000);
        send_byte({ADDR, 1'b0}, ack);
        chk("R10 idle after stall", {15'h0, ack}, 16'h0000);
        bus_stop();
        rd_reg(8'h02, v);
        chk("R10 recovers after stall", v, exp_reg(8'h02));

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule